// File: doc/BRIEF.md
# Four-Beat Line Burst Slave

This block is a slave on a 32-bit system bus. It serves both cache-line burst transfers and single transfers against a simple word-addressed local memory port. A transfer begins when the master pulses a transfer-start strobe. The strobe arrives with an address, a direction, a size code and a burst flag.

For a burst, the master keeps the in-line word bits of the address fixed for the whole transfer. The slave therefore supplies the word index itself. It loads a small counter from byte-address bits [3:2] and steps it by one, modulo four, after every beat. Each beat ends with a one-cycle transfer acknowledge, and the block returns to idle after the fourth. A configurable number of wait cycles comes before the first beat, and another configurable number comes before each later beat.

A request the block cannot serve ends at once with a one-cycle transfer error acknowledge. Such a request is a burst that is misaligned or narrower than a word, or a single transfer that is misaligned for its size. While a transfer is in progress, further start strobes are ignored.

Top module: `burst_line_slave`

## Requirements
- R1: After reset, `ta_o`, `tea_o`, `mem_we_o` and `mem_re_o` are low, and they stay low until a start strobe is sampled.
- R2: A legal burst (`burst_i`=1) gives exactly four `ta_o` pulses, each one cycle long, and no further acknowledge until the next accepted start.
- R3: During a burst, `mem_addr_o` is {byte-address bits [ADDR_W-1:4], word index}. The word index equals byte-address bits [3:2] on the first beat and grows by one, modulo 4, on each later beat. The order is therefore critical word first, wrapping inside the line.
- R4: If the start is sampled at clock edge k, the first `ta_o` is high in the cycle after edge k+WS_FIRST. Each later beat of a burst follows the previous acknowledge after exactly WS_NEXT low cycles.
- R5: A burst whose size code is not 2'b00 (word) or whose byte-address bits [1:0] are nonzero gets one `tea_o` cycle right after the start edge. It gets no `ta_o` and causes no memory access.
- R6: A single transfer (`burst_i`=0) gets exactly one `ta_o`, timed as the first beat in R4. Its lane mask `mem_be_o` is big-endian, with bit 3 = data bits 31:24. A byte at offset k (size 2'b01) enables bit 3-k. A half-word (size 2'b10) enables 4'b1100 at offset 0 and 4'b0011 at offset 2. A word (size 2'b00) enables 4'b1111. Every burst beat enables 4'b1111.
- R7: A single transfer is answered with one `tea_o` cycle and no `ta_o` in three cases: a word at a nonzero offset, a half-word at an odd offset, or size code 2'b11.
- R8: A start strobe sampled while a transfer is in progress is ignored. The running transfer keeps its addresses and beat count, and no extra transfer follows.
- R9: In an acknowledge cycle of a read (`rnw_i`=1), `mem_re_o` is high and `rdata_o` equals `mem_rdata_i`. In an acknowledge cycle of a write, `mem_we_o` is high and `mem_wdata_o` equals `wdata_i`. Outside acknowledge cycles, `mem_we_o` and `mem_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 1 | Transfer start strobe |
| burst_i | input | 1 | 1 = four-beat line burst, 0 = single transfer |
| rnw_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | 00 word, 01 byte, 10 half-word, 11 illegal |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data from the master |
| rdata_o | output | 32 | Read data to the master, valid with `ta_o` |
| ta_o | output | 1 | Transfer acknowledge, one pulse per beat |
| tea_o | output | 1 | Transfer error acknowledge |
| mem_addr_o | output | ADDR_W-2 | Local memory word address |
| mem_re_o | output | 1 | Local memory read strobe |
| mem_we_o | output | 1 | Local memory write strobe |
| mem_be_o | output | 4 | Local memory byte-lane mask, bit 3 = bits 31:24 |
| mem_wdata_o | output | 32 | Local memory write data |
| mem_rdata_i | input | 32 | Local memory read data, combinational from `mem_addr_o` |

## Verification
The assertions check on every cycle that acknowledge and error acknowledge never coincide. They also check that an error lasts one cycle, that the word index steps by one while the line bits hold, that a burst never exceeds four acknowledges, and that a busy transfer is not disturbed by a new start. Only the bench scenarios can show the wrapped address order for every start word and line, the exact acknowledge cycles under both wait settings, the full table of byte-lane masks and legal or illegal size and offset pairs, and that burst data actually lands in and returns from the local memory.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT  = 2'd1,
    ST_FAULT = 2'd2
  } bsq_state_e;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  // Big-endian byte lanes: bit 3 carries data bits 31:24 (offset 0).
  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] m;
    case (sz)
      SZ_BYTE: m = 4'b1000 >> off;
      SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  // Legality of a request: bursts must be aligned words.
  function automatic logic req_legal(input logic burst, input logic [1:0] sz,
                                     input logic [1:0] off);
    logic ok;
    if (burst) begin
      ok = (sz == SZ_WORD) && (off == 2'b00);
    end else begin
      case (sz)
        SZ_WORD: ok = (off == 2'b00);
        SZ_BYTE: ok = 1'b1;
        SZ_HALF: ok = (off[0] == 1'b0);
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/bsq_req_check.sv
module bsq_req_check
  import bsq_pkg::*;
(
  input  logic       burst_i,
  input  logic [1:0] size_i,
  input  logic [1:0] off_i,
  output logic       legal_o,
  output logic [3:0] be_o
);

  always_comb begin
    legal_o = req_legal(burst_i, size_i, off_i);
    be_o    = burst_i ? 4'b1111 : lane_mask(size_i, off_i);
  end

  // R6: a legal byte request enables exactly one lane
  always_comb begin
    if (legal_o && !burst_i && size_i == SZ_BYTE)
      a_r6_byte_one_lane: assert ($countones(be_o) == 1);
  end

endmodule

// File: rtl/bsq_wait_timer.sv
module bsq_wait_timer #(
  parameter int WS_FIRST = 1,
  parameter int WS_NEXT  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  input  logic active_i,
  output logic due_o
);

  localparam int WS_MAX = (WS_FIRST > WS_NEXT) ? WS_FIRST : WS_NEXT;
  localparam int CW     = (WS_MAX < 1) ? 1 : $clog2(WS_MAX + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (start_i)                 cnt_q <= CW'(WS_FIRST);
    else if (ack_i)                   cnt_q <= CW'(WS_NEXT);
    else if (active_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign due_o = (cnt_q == '0);

  generate
    if (WS_NEXT > 0) begin : g_next_gap
      // R4: a beat is never followed at once by another beat when gaps are set
      a_r4_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !due_o);
    end
    if (WS_FIRST > 0) begin : g_first_gap
      // R4: no beat in the cycle right after acceptance when first waits are set
      a_r4_gap_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !due_o);
    end
  endgenerate

endmodule

// File: rtl/bsq_word_seq.sv
module bsq_word_seq #(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              advance_i,
  output logic [ADDR_W-3:0] word_addr_o,
  output logic              last_o
);

  localparam int IDX_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = ADDR_W - 2 - IDX_W;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      idx_q  <= '0;
      beat_q <= '0;
    end else if (start_i) begin
      line_q <= addr_i[ADDR_W-1:IDX_W+2];
      idx_q  <= addr_i[IDX_W+1:2];
      beat_q <= '0;
    end else if (advance_i) begin
      idx_q  <= step_idx(idx_q);
      beat_q <= beat_q + 1'b1;
    end
  end

  assign word_addr_o = {line_q, idx_q};
  assign last_o      = (beat_q == IDX_W'(LINE_WORDS - 1));

  // R3: the word index advances by one, wrapping within the line
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !start_i) |=> idx_q == IDX_W'($past(idx_q) + 1));
  // R3: the line bits never move without a new start
  a_r3_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(line_q));

endmodule

// File: rtl/burst_line_slave.sv
module burst_line_slave
  import bsq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  parameter int WS_FIRST   = 1,
  parameter int WS_NEXT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_i,
  input  logic              burst_i,
  input  logic              rnw_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ta_o,
  output logic              tea_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i
);

  localparam int CNT_W = $clog2(LINE_WORDS) + 1;

  bsq_state_e state_q;
  logic       burst_q, rnw_q;
  logic [3:0] be_q;
  logic       legal, due, seq_last;
  logic [3:0] be_req;

  // Named internal events
  logic accept, beat_ack, final_ack;
  logic [CNT_W-1:0] ack_cnt_q;

  assign accept    = (state_q == ST_IDLE) && ts_i;
  assign beat_ack  = (state_q == ST_BEAT) && due;
  assign final_ack = beat_ack && (!burst_q || seq_last);

  bsq_req_check u_check (
    .burst_i (burst_i),
    .size_i  (size_i),
    .off_i   (addr_i[1:0]),
    .legal_o (legal),
    .be_o    (be_req)
  );

  bsq_wait_timer #(.WS_FIRST(WS_FIRST), .WS_NEXT(WS_NEXT)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept && legal),
    .ack_i    (beat_ack),
    .active_i (state_q == ST_BEAT),
    .due_o    (due)
  );

  bsq_word_seq #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .addr_i      (addr_i),
    .advance_i   (beat_ack),
    .word_addr_o (mem_addr_o),
    .last_o      (seq_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      rnw_q   <= 1'b0;
      be_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (ts_i) begin
          state_q <= legal ? ST_BEAT : ST_FAULT;
          burst_q <= burst_i;
          rnw_q   <= rnw_i;
          be_q    <= be_req;
        end
        ST_BEAT:  if (final_ack) state_q <= ST_IDLE;
        ST_FAULT: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accept) ack_cnt_q <= '0;
    else if (beat_ack)    ack_cnt_q <= ack_cnt_q + 1'b1;
  end

  assign ta_o        = beat_ack;
  assign tea_o       = (state_q == ST_FAULT);
  assign mem_re_o    = beat_ack && rnw_q;
  assign mem_we_o    = beat_ack && !rnw_q;
  assign mem_be_o    = be_q;
  assign mem_wdata_o = wdata_i;
  assign rdata_o     = (beat_ack && rnw_q) ? mem_rdata_i : 32'h0;

  // R2: no cycle carries both kinds of acknowledge
  a_r2_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ta_o && tea_o));
  // R2: a transfer never acknowledges more than a line of beats
  a_r2_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ta_o |-> ack_cnt_q < CNT_W'(LINE_WORDS));
  // R2: the final acknowledge leaves the block idle
  a_r2_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    final_ack |=> !ta_o && !tea_o);
  // R5: an error acknowledge lasts one cycle and moves no data
  a_r5_tea_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |=> !tea_o && !mem_we_o && !mem_re_o);
  // R8: a running transfer is not disturbed by a new start
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BEAT && !final_ack) |=>
      (state_q == ST_BEAT && $stable(rnw_q) && $stable(burst_q)));
  // R9: memory strobes only accompany acknowledges
  a_r9_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> ta_o);

endmodule

// File: tb/tb_burst_line_slave.sv
module tb_burst_line_slave;

  localparam int ADDR_W = 6;
  localparam int WSF    = 2;
  localparam int WSN    = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ts_i = 1'b0, burst_i = 1'b0, rnw_i = 1'b0;
  logic [1:0]        size_i = 2'b00;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o, mem_wdata_o, mem_rdata_i;
  logic              ta_o, tea_o, mem_re_o, mem_we_o;
  logic [ADDR_W-3:0] mem_addr_o;
  logic [3:0]        mem_be_o;

  always #2.5 clk = ~clk;

  burst_line_slave #(.ADDR_W(ADDR_W), .LINE_WORDS(4), .WS_FIRST(WSF), .WS_NEXT(WSN)) dut (
    .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .burst_i(burst_i), .rnw_i(rnw_i),
    .size_i(size_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .ta_o(ta_o), .tea_o(tea_o), .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o),
    .mem_we_o(mem_we_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];
  assign mem_rdata_i = mem[mem_addr_o];

  always @(posedge clk) begin
    if (mem_we_o) begin
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
    end
  end

  int nvec = 0, nfail = 0;
  int nack, ntea, tea_cyc;
  int          ack_cyc  [8];
  logic [3:0]  ack_addr [8];
  logic [31:0] ack_data [8];
  logic [3:0]  ack_be   [8];
  logic        ack_we   [8];
  logic [31:0] ack_wd   [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic b, input logic rnw, input logic [1:0] sz,
                      input logic [ADDR_W-1:0] a, input logic inject,
                      input logic [31:0] tag);
    nack = 0; ntea = 0; tea_cyc = -1;
    @(negedge clk);
    burst_i = b; rnw_i = rnw; size_i = sz; addr_i = a; ts_i = 1'b1; wdata_i = tag;
    for (int c = 1; c <= 24; c++) begin
      @(negedge clk);
      ts_i = inject && (c == 2);
      if (inject && c == 2) begin
        addr_i = a ^ 6'h34; rnw_i = ~rnw; burst_i = 1'b0;
      end
      wdata_i = tag + nack;
      if (ta_o && nack < 8) begin
        ack_cyc[nack]  = c;
        ack_addr[nack] = mem_addr_o;
        ack_data[nack] = rdata_o;
        ack_be[nack]   = mem_be_o;
        ack_we[nack]   = mem_we_o;
        ack_wd[nack]   = mem_wdata_o;
        nack++;
      end
      if (tea_o) begin
        if (tea_cyc < 0) tea_cyc = c;
        ntea++;
      end
    end
  endtask

  task automatic burst_case(input int line, input int s, input logic rnw, input logic inject);
    logic [ADDR_W-1:0] a;
    logic [31:0] tag;
    int w;
    a   = ADDR_W'(line * 16 + s * 4);
    tag = 32'h5000_0000 + 32'(line * 256 + s * 16);
    xfer(1'b1, rnw, 2'b00, a, inject, tag);
    chk(nack == 4, inject ? "R8 beat count" : "R2 beat count", nack, 4);
    chk(ntea == 0, "R2 no error", ntea, 0);
    for (int k = 0; k < 4 && k < nack; k++) begin
      w = line * 4 + (s + k) % 4;
      chk(ack_addr[k] == 4'(w), inject ? "R8 address" : "R3 wrap address", ack_addr[k], w);
      chk(ack_cyc[k] == 1 + WSF + k * (1 + WSN), "R4 beat timing", ack_cyc[k],
          1 + WSF + k * (1 + WSN));
      chk(ack_be[k] == 4'b1111, "R6 burst lanes", ack_be[k], 4'hF);
      if (rnw) begin
        chk(ack_data[k] == exp_mem[w], "R9 read data", ack_data[k], exp_mem[w]);
      end else begin
        chk(ack_we[k] && ack_wd[k] == tag + k, "R9 write data", ack_wd[k], tag + k);
        exp_mem[w] = tag + 32'(k);
      end
    end
    if (!rnw)
      for (int i = 0; i < 4; i++)
        chk(mem[line*4+i] == exp_mem[line*4+i], "R9 memory contents",
            mem[line*4+i], exp_mem[line*4+i]);
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", nvec, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [3:0] exp_be;
    logic legal;
    int w;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'hA000_0000 + 32'(i * 32'h111);
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: outputs idle under and after reset
    chk(!ta_o && !tea_o && !mem_we_o && !mem_re_o, "R1 reset outputs",
        {ta_o, tea_o, mem_we_o, mem_re_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!ta_o && !tea_o && !mem_we_o && !mem_re_o, "R1 idle after reset",
        {ta_o, tea_o, mem_we_o, mem_re_o}, 0);

    // R2 R3 R4 R9: every line and start word, reads then writes then reads
    for (int line = 0; line < 4; line++)
      for (int s = 0; s < 4; s++) begin
        burst_case(line, s, 1'b1, 1'b0);
        burst_case(line, s, 1'b0, 1'b0);
        burst_case(line, s, 1'b1, 1'b0);
      end

    // R5: illegal burst size and offset pairs
    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++) begin
        if (sz == 0 && off == 0) continue;
        xfer(1'b1, 1'b0, 2'(sz), ADDR_W'(16 + 8 + off), 1'b0, 32'hDEAD0000);
        chk(ntea == 1 && tea_cyc == 1, "R5 burst error pulse", tea_cyc, 1);
        chk(nack == 0, "R5 no beats", nack, 0);
        chk(mem[6] == exp_mem[6], "R5 memory untouched", mem[6], exp_mem[6]);
      end

    // R6 R7: single transfers over all sizes, offsets and directions
    for (int rw = 0; rw < 2; rw++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++) begin
          legal  = (sz == 1) || (sz == 2 && off % 2 == 0) || (sz == 0 && off == 0);
          exp_be = (sz == 1) ? 4'(1 << (3 - off)) :
                   (sz == 2) ? ((off >= 2) ? 4'b0011 : 4'b1100) : 4'b1111;
          w = 9;
          xfer(1'b0, rw[0], 2'(sz), ADDR_W'(w * 4 + off), 1'b0,
               32'hC0DE_0000 + 32'(rw * 64 + sz * 4 + off) * 32'h01010101);
          if (legal) begin
            chk(nack == 1 && ntea == 0, "R6 single beat", nack, 1);
            chk(ack_cyc[0] == 1 + WSF, "R6 single timing", ack_cyc[0], 1 + WSF);
            chk(ack_be[0] == exp_be, "R6 lane mask", ack_be[0], exp_be);
            chk(ack_addr[0] == 4'(w), "R6 single address", ack_addr[0], w);
            if (rw == 1) begin
              chk(ack_data[0] == exp_mem[w], "R9 single read", ack_data[0], exp_mem[w]);
            end else begin
              for (int b = 0; b < 4; b++)
                if (exp_be[b]) exp_mem[w][b*8 +: 8] = ack_wd[0][b*8 +: 8];
              chk(mem[w] == exp_mem[w], "R9 single merge", mem[w], exp_mem[w]);
            end
          end else begin
            chk(ntea == 1 && tea_cyc == 1, "R7 single error", tea_cyc, 1);
            chk(nack == 0, "R7 no beat", nack, 0);
          end
        end

    // R8: start strobes during a running burst are ignored
    burst_case(2, 1, 1'b1, 1'b1);
    burst_case(3, 3, 1'b0, 1'b1);
    burst_case(3, 0, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule